// File: doc/BRIEF.md
# Management Data Interface Master

This block is the host-facing master of a two-wire PHY management bus. Software reaches it through three registers: an address register (port, device and register address), a data register (start/busy flag, command, addressing style, clock select and the 16-bit payload) and a port-type register. The port-type register lists which of the low ports use the short single-frame addressing style, Clause 22. The host loads the address register first. A write to the data register with the start bit set then launches the operation.

A Clause 22 operation sends one frame. A Clause 45 operation sends an address frame followed by a read or write frame. Every frame starts with a 32-bit preamble of ones. MDC is divided down from the system clock under control of the clock-select field. The line changes while MDC is low, and the PHY's read data is sampled on the MDC rising edge. Some accesses are illegal: a Clause 22 access to a port that is not enabled for it, or an unknown command. These are not issued. A sticky error flag is raised instead.

Top module: `mdio_mst`

## Requirements
- R1: After reset all three registers read zero, and MDC and the output enable are low.
- R2: A data-register write with bit 22 set and a legal command launches the operation. Bit 22 reads 1 from the cycle after that write until the operation is over.
- R3: A Clause 22 operation (data bit 18 = 1) sends exactly one 64-bit frame: 32 ones, start 01, op 01 for write or 10 for read, port = address bits 20:16, register = address bits 4:0, turnaround 10, then 16 data bits MSB first.
- R4: A Clause 45 operation (data bit 18 = 0) sends two frames. The first is the address frame: start 00, op 00, port, device = address bits 25:21, turnaround 10, then address bits 15:0. The second has start 00, op 01 (write) or 11 (read), port, device, turnaround 10 and the data.
- R5: For a read, the master releases the line for the turnaround and the data bits. It samples 16 bits on MDC rising edges, MSB first, and the result sits in data bits 15:0 once busy clears.
- R6: The MDC period is 2*DIV_BASE*(sel+1) clock cycles, where sel is data bits 21:19.
- R7: The port-type register keeps bits 3:0 (one per port; a set bit marks that port as Clause 22). Its upper bits read zero.
- R8: A Clause 22 launch to a port above 3, or to a port whose port-type bit is clear, sends no frame. It sets the error flag (data bit 23) and leaves busy at 0.
- R9: A launch with a command field (data bits 17:16) other than 01 (write) or 11 (read) sends no frame and sets the error flag.
- R10: The error flag stays set until the next accepted data-register write. That write clears it, unless the write is itself an illegal launch.
- R11: Address-register and data-register writes made while busy are ignored. The frames on the wire and the register contents stay unchanged.
- R12: A data-register write with bit 22 clear stores its fields without launching anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Write target: 0 address, 1 data, 2 port type |
| wr_data_i | input | 32 | Host write data |
| rd_sel_i | input | 2 | Read target, same coding as wr_sel_i |
| rd_data_o | output | 32 | Selected register contents (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Busy and the error flag change on the clock edge that takes the data-register write. The bench therefore reads them at the falling edge right after its write strobe. Frame contents only become final on MDC rising edges, so a bus model records the line on each MDC rise and compares whole 64-bit frames once busy has dropped. Read results and the restored register contents are checked only after busy is observed low. The MDC period is measured between the first two rising edges of each frame.

// File: rtl/mdio_mst_pkg.sv
package mdio_mst_pkg;
  localparam int ERR_B    = 23;
  localparam int BUSY_B   = 22;
  localparam int CSEL_LSB = 19;
  localparam int C22_B    = 18;
  localparam int CMD_LSB  = 16;
  localparam int PA_LSB   = 16;
  localparam int DA_LSB   = 21;
  localparam logic [1:0] CMD_WR = 2'b01;
  localparam logic [1:0] CMD_RD = 2'b11;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_XFER} seq_e;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  pa;
    logic [4:0]  ra;
    logic [1:0]  ta;
    logic [15:0] dat;
  } frame_t;
endpackage

// File: rtl/mdio_mst_clkgen.sv
module mdio_mst_clkgen #(
  parameter int DIV_BASE = 2,
  parameter int CSEL_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CSEL_W-1:0] csel_i,
  output logic              tick_o
);
  localparam int CNT_W = $clog2(DIV_BASE * (1 << CSEL_W) + 1);

  logic [CNT_W-1:0] cnt_q, half;

  assign half   = CNT_W'(DIV_BASE * (int'(csel_i) + 1));
  assign tick_o = en_i && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/mdio_mst_frame.sv
module mdio_mst_frame import mdio_mst_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  frame_t      frame_i,
  input  logic        rd_i,
  input  logic        tick_i,
  input  logic        mdio_i,
  output logic        active_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam logic [5:0] PRE_LEN = 6'd32;
  localparam logic [5:0] LAST    = 6'd63;
  localparam logic [5:0] REL_IDX = 6'd46;  // first turnaround bit
  localparam logic [5:0] DAT_IDX = 6'd48;

  logic        active_q, ph_q, done_q, rd_q;
  logic [5:0]  idx_q;
  logic [31:0] fr_q;
  logic [15:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= 1'b0;
      done_q   <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      fr_q     <= '0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        ph_q     <= 1'b0;
        idx_q    <= '0;
        fr_q     <= frame_i;
        rd_q     <= rd_i;
      end else if (active_q && tick_i) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
          if (rd_q && idx_q >= DAT_IDX) rdata_q <= {rdata_q[14:0], mdio_i};
        end else begin
          ph_q <= 1'b0;
          if (idx_q == LAST) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_q + 6'd1;
          end
        end
      end
    end
  end

  assign active_o  = active_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign mdc_o     = active_q & ph_q;
  assign mdio_o    = (!active_q || idx_q < PRE_LEN) ? 1'b1 : fr_q[~idx_q[4:0]];
  assign mdio_oe_o = active_q & ~(rd_q & (idx_q >= REL_IDX));
endmodule

// File: rtl/mdio_mst.sv
module mdio_mst import mdio_mst_pkg::*; #(
  parameter int DIV_BASE  = 2,
  parameter int CSEL_W    = 3,
  parameter int C22_PORTS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  output logic [31:0] rd_data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int AW = DA_LSB + 5;

  logic [AW-1:0]        addr_q;
  logic [C22_PORTS-1:0] ptype_q;
  logic [15:0]          data_q;
  logic [1:0]           cmd_q;
  logic                 c22_q, busy_q, err_q, go_q;
  logic [CSEL_W-1:0]    csel_q;
  seq_e                 st_q;

  logic acc_addr, acc_data, wr_ptype, w_start, w_c22, cmd_ok, c22_ok;
  logic launch_ok, launch_bad;
  logic [1:0] w_cmd;
  logic [4:0] port, dev;
  logic eng_active, eng_done, eng_rd, tick;
  logic [15:0] eng_rdata;
  frame_t fr;

  assign acc_addr = wr_en_i && !busy_q && wr_sel_i == 2'd0;
  assign acc_data = wr_en_i && !busy_q && wr_sel_i == 2'd1;
  assign wr_ptype = wr_en_i && wr_sel_i == 2'd2;
  assign w_start  = wr_data_i[BUSY_B];
  assign w_c22    = wr_data_i[C22_B];
  assign w_cmd    = wr_data_i[CMD_LSB +: 2];
  assign port     = addr_q[PA_LSB +: 5];
  assign dev      = addr_q[DA_LSB +: 5];
  assign cmd_ok   = (w_cmd == CMD_WR) || (w_cmd == CMD_RD);

  always_comb begin
    c22_ok = 1'b0;
    for (int i = 0; i < C22_PORTS; i++)
      if (port == 5'(i) && ptype_q[i]) c22_ok = 1'b1;
  end

  assign launch_ok  = acc_data && w_start && cmd_ok && (!w_c22 || c22_ok);
  assign launch_bad = acc_data && w_start && !(cmd_ok && (!w_c22 || c22_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      ptype_q <= '0;
      data_q  <= '0;
      cmd_q   <= '0;
      c22_q   <= 1'b0;
      csel_q  <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      go_q    <= 1'b0;
      st_q    <= SQ_IDLE;
    end else begin
      go_q <= 1'b0;
      if (acc_addr) addr_q <= wr_data_i[AW-1:0];
      if (wr_ptype) ptype_q <= wr_data_i[C22_PORTS-1:0];
      if (acc_data) begin
        data_q <= wr_data_i[15:0];
        cmd_q  <= w_cmd;
        c22_q  <= w_c22;
        csel_q <= wr_data_i[CSEL_LSB +: CSEL_W];
        err_q  <= launch_bad;
      end
      if (launch_ok) begin
        busy_q <= 1'b1;
        go_q   <= 1'b1;
        st_q   <= w_c22 ? SQ_XFER : SQ_ADDR;
      end
      if (eng_done) begin
        if (st_q == SQ_ADDR) begin
          go_q <= 1'b1;
          st_q <= SQ_XFER;
        end else begin
          busy_q <= 1'b0;
          st_q   <= SQ_IDLE;
          if (cmd_q == CMD_RD) data_q <= eng_rdata;
        end
      end
    end
  end

  // frame contents follow the stored registers; the engine latches them on go_q
  always_comb begin
    fr.pa  = port;
    fr.ta  = 2'b10;
    fr.dat = data_q;
    if (st_q == SQ_ADDR) begin
      fr.st  = 2'b00;
      fr.op  = 2'b00;
      fr.ra  = dev;
      fr.dat = addr_q[15:0];
    end else if (c22_q) begin
      fr.st = 2'b01;
      fr.op = (cmd_q == CMD_RD) ? 2'b10 : 2'b01;
      fr.ra = addr_q[4:0];
    end else begin
      fr.st = 2'b00;
      fr.op = cmd_q;
      fr.ra = dev;
    end
  end

  assign eng_rd = (st_q == SQ_XFER) && (cmd_q == CMD_RD);

  mdio_mst_clkgen #(.DIV_BASE(DIV_BASE), .CSEL_W(CSEL_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (eng_active),
    .csel_i (csel_q),
    .tick_o (tick)
  );

  mdio_mst_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (go_q),
    .frame_i   (fr),
    .rd_i      (eng_rd),
    .tick_i    (tick),
    .mdio_i    (mdio_i),
    .active_o  (eng_active),
    .done_o    (eng_done),
    .rdata_o   (eng_rdata),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_sel_i)
      2'd0: rd_data_o = 32'(addr_q);
      2'd1: begin
        rd_data_o[15:0]                = data_q;
        rd_data_o[CMD_LSB +: 2]        = cmd_q;
        rd_data_o[C22_B]               = c22_q;
        rd_data_o[CSEL_LSB +: CSEL_W]  = csel_q;
        rd_data_o[BUSY_B]              = busy_q;
        rd_data_o[ERR_B]               = err_q;
      end
      2'd2: rd_data_o = 32'(ptype_q);
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mst_chk.sv
module mdio_mst_chk #(
  parameter int AW     = 26,
  parameter int CSEL_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_q,
  input logic              err_q,
  input logic              mdc_o,
  input logic              mdio_oe_o,
  input logic [AW-1:0]     addr_q,
  input logic [CSEL_W-1:0] csel_q,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!mdc_o && !mdio_oe_o));  // R8
  AST_ERR_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> !busy_q);  // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_en_i && wr_sel_i == 2'd1 && !busy_q)) |=> err_q);  // R10
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(addr_q));  // R11
  AST_CSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(csel_q));  // R6
endmodule

bind mdio_mst mdio_mst_chk #(.AW(AW), .CSEL_W(CSEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_q    (busy_q),
  .err_q     (err_q),
  .mdc_o     (mdc_o),
  .mdio_oe_o (mdio_oe_o),
  .addr_q    (addr_q),
  .csel_q    (csel_q),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i)
);

// File: tb/mdio_mst_tb.sv
module mdio_mst_tb;
  localparam int CLK_P    = 10;
  localparam int DIV_BASE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic mdc, mdio_out, mdio_oe;
  logic mdio_in = 1'b1;

  int ncheck = 0, nfail = 0;
  int nbits = 0, nfr = 0, meas_per = 0;
  logic rdfr = 1'b0;
  logic [63:0] sh = '0;
  logic [63:0] cap [0:1];
  logic [15:0] phy_rd = '0;
  longint t_prev = 0;

  always #(CLK_P/2) clk = ~clk;

  mdio_mst #(.DIV_BASE(DIV_BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // bus model: record the line on MDC rise, answer reads on MDC fall
  always @(posedge mdc) begin
    if (nbits == 1) meas_per = int'(($time - t_prev) / CLK_P);
    t_prev = $time;
    sh = {sh[62:0], mdio_oe ? mdio_out : mdio_in};
    nbits++;
    if (nbits == 36) rdfr = (sh[3:0] == 4'b0110) || (sh[3:0] == 4'b0011);
    if (nbits == 64) begin
      if (nfr < 2) cap[nfr] = sh;
      nfr++;
      nbits = 0;
      rdfr = 1'b0;
    end
  end

  always @(negedge mdc) begin
    if (rdfr && nbits == 47) mdio_in = 1'b0;
    else if (rdfr && nbits >= 48) mdio_in = phy_rd[63-nbits];
    else mdio_in = 1'b1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    ncheck++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  endtask

  task automatic hw(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic wait_idle;
    logic [31:0] v;
    int n = 0;
    do begin
      @(negedge clk);
      rdreg(2'd1, v);
      n++;
    end while (v[22] && n < 10000);
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

  function automatic logic [31:0] data_word(input bit start, input logic [2:0] cs,
      input bit c22, input logic [1:0] cmd, input logic [15:0] d);
    return (32'(start) << 22) | (32'(cs) << 19) | (32'(c22) << 18) | (32'(cmd) << 16) | 32'(d);
  endfunction

  task automatic do_op(input bit c22, input logic [4:0] port, input logic [4:0] dev,
      input logic [15:0] ra, input bit rd, input logic [15:0] wd, input logic [2:0] cs);
    logic [31:0] v;
    logic [15:0] ed;
    phy_rd = 16'($urandom);
    hw(2'd0, {6'b0, dev, port, ra});
    nfr = 0; nbits = 0;
    hw(2'd1, data_word(1'b1, cs, c22, rd ? 2'b11 : 2'b01, wd));
    rdreg(2'd1, v);
    chk("R2 busy after launch", 64'(v[22]), 64'd1);
    wait_idle();
    ed = rd ? phy_rd : wd;
    if (c22) begin
      chk("R3 frame count", 64'(nfr), 64'd1);
      chk("R3 frame", cap[0], exp_frame(2'b01, rd ? 2'b10 : 2'b01, port, ra[4:0], ed));
    end else begin
      chk("R4 frame count", 64'(nfr), 64'd2);
      chk("R4 address frame", cap[0], exp_frame(2'b00, 2'b00, port, dev, ra));
      chk("R4 data frame", cap[1], exp_frame(2'b00, rd ? 2'b11 : 2'b01, port, dev, ed));
    end
    rdreg(2'd1, v);
    chk("R2 busy cleared", 64'(v[22]), 64'd0);
    chk(rd ? "R5 read data" : "R3 write data kept", 64'(v[15:0]), 64'(ed));
    chk("R6 mdc period", 64'(meas_per), 64'(2 * DIV_BASE * (int'(cs) + 1)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      rdreg(2'(s), v);
      chk("R1 register reset", 64'(v), 64'd0);
    end
    chk("R1 mdc low", 64'(mdc), 64'd0);
    chk("R1 oe low", 64'(mdio_oe), 64'd0);

    // R7 port-type width
    hw(2'd2, 32'hFFFF_FFFF);
    rdreg(2'd2, v);
    chk("R7 port type bits", 64'(v), 64'hF);

    // directed frames
    do_op(1'b1, 5'd0, 5'd0, 16'h0005, 1'b0, 16'hA55A, 3'd0);
    do_op(1'b1, 5'd3, 5'd0, 16'hFFFF, 1'b1, 16'h0000, 3'd1);
    do_op(1'b0, 5'd9, 5'd3, 16'hABCD, 1'b0, 16'h1234, 3'd0);
    do_op(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b1, 16'h0000, 3'd2);
    do_op(1'b1, 5'd2, 5'd0, 16'h001F, 1'b0, 16'h8001, 3'd7);

    // R8 illegal Clause 22 targets
    hw(2'd2, 32'h5);
    hw(2'd0, {6'b0, 5'd0, 5'd1, 16'd2});
    nbits = 0; nfr = 0;
    hw(2'd1, data_word(1'b1, 3'd0, 1'b1, 2'b01, 16'h1111));
    rdreg(2'd1, v);
    chk("R8 error on disabled port", 64'(v[23]), 64'd1);
    chk("R8 no busy on disabled port", 64'(v[22]), 64'd0);
    repeat (50) @(negedge clk);
    chk("R8 no mdc activity", 64'(nbits + nfr), 64'd0);
    hw(2'd0, {6'b0, 5'd0, 5'd4, 16'd2});
    hw(2'd1, data_word(1'b1, 3'd0, 1'b1, 2'b11, 16'h0));
    rdreg(2'd1, v);
    chk("R8 error on port 4", 64'(v[23:22]), 64'b10);

    // R10 sticky across other register writes
    hw(2'd2, 32'hF);
    hw(2'd0, {6'b0, 5'd1, 5'd1, 16'd1});
    rdreg(2'd1, v);
    chk("R10 error sticky", 64'(v[23]), 64'd1);

    // R12 store without launch, also clears error (R10)
    nbits = 0; nfr = 0;
    hw(2'd1, data_word(1'b0, 3'd5, 1'b1, 2'b01, 16'h1234));
    rdreg(2'd1, v);
    chk("R12 fields stored", 64'(v), 64'(data_word(1'b0, 3'd5, 1'b1, 2'b01, 16'h1234)));
    chk("R10 error cleared", 64'(v[23]), 64'd0);
    repeat (50) @(negedge clk);
    chk("R12 no frame", 64'(nbits + nfr), 64'd0);

    // R9 illegal commands
    hw(2'd1, data_word(1'b1, 3'd0, 1'b0, 2'b10, 16'h0));
    rdreg(2'd1, v);
    chk("R9 cmd 10 rejected", 64'(v[23:22]), 64'b10);
    hw(2'd1, data_word(1'b1, 3'd0, 1'b0, 2'b00, 16'h0));
    rdreg(2'd1, v);
    chk("R9 cmd 00 rejected", 64'(v[23:22]), 64'b10);
    repeat (50) @(negedge clk);
    chk("R9 no frame", 64'(nbits + nfr), 64'd0);

    // R11 writes while busy
    phy_rd = 16'h0;
    hw(2'd0, {6'b0, 5'd7, 5'd12, 16'h4321});
    nfr = 0; nbits = 0;
    hw(2'd1, data_word(1'b1, 3'd0, 1'b0, 2'b01, 16'hBEEF));
    rdreg(2'd1, v);
    chk("R10 legal launch clears error", 64'(v[23]), 64'd0);
    hw(2'd0, 32'h03FF_FFFF);
    hw(2'd1, data_word(1'b1, 3'd3, 1'b1, 2'b11, 16'h0));
    rdreg(2'd0, v);
    chk("R11 address held", 64'(v), 64'({6'b0, 5'd7, 5'd12, 16'h4321}));
    wait_idle();
    chk("R11 address frame", cap[0], exp_frame(2'b00, 2'b00, 5'd12, 5'd7, 16'h4321));
    chk("R11 data frame", cap[1], exp_frame(2'b00, 2'b01, 5'd12, 5'd7, 16'hBEEF));
    rdreg(2'd1, v);
    chk("R11 data reg held", 64'(v), 64'(data_word(1'b0, 3'd0, 1'b0, 2'b01, 16'hBEEF)));

    // random mix
    for (int i = 0; i < 20; i++) begin
      bit c22 = 1'($urandom % 2);
      logic [4:0] port = c22 ? 5'($urandom % 4) : 5'($urandom);
      do_op(c22, port, 5'($urandom), 16'($urandom), 1'($urandom % 2),
            16'($urandom), 3'($urandom % 3));
    end
    report();
  end
endmodule